// File: doc/BRIEF.md
# Credit-Throttled Instruction Fetch Controller

This block is the front of an out-of-order core. Each cycle it asks an instruction memory for a run of consecutive instruction words. The run starts at the current fetch PC and has at most `LANES` words. The run length is set by free-space credit that the reorder buffer reports back. Right after reset the credit loop has not yet produced a value, so the first two cycles always ask for the full width. From then on, the request length follows the credit reported two cycles earlier.

Each returned word is checked for a branch opcode. A branch gets a predicted target of its own PC plus one, because every branch is assumed to fall through. The words, their PCs, the branch flags and the targets are registered and passed to the rename stage as a group one cycle later. Each slot carries a valid bit, so a partly filled or empty group can be expressed.

When the reorder buffer signals a flush, the next fetch starts at the instruction after the last retired one. Otherwise the PC moves past the words just requested. The instruction memory is read combinationally through one address/enable pair and one data bus per lane.

Top module: `fetch_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `grp_valid_o` is all zeros.
- R2: In the first cycle after reset, lane 0 asks for address 256.
- R3: In the first two cycles after reset, all `LANES` enables are high, whatever the credit input.
- R4: From the third cycle after reset on, the number of enables equals the `credit_i` value driven two cycles earlier, clamped to `LANES`. The enables always form a contiguous run that starts at lane 0.
- R5: Lane i asks for address PC + i.
- R6: With `flush_i` low, the next cycle's PC is the current PC plus the number of lanes requested. A request of zero lanes keeps the PC unchanged.
- R7: With `flush_i` high, the next cycle's PC is `retired_pc_i` + 1, wrapping modulo 2^AW.
- R8: A word whose top 4 bits equal 4'hB is a branch. Its slot has `grp_branch_o` set and `grp_target_o` equal to its PC + 1. Any other valid slot has its flag and target at zero.
- R9: The group output in cycle k+1 has valid bits equal to the enables of cycle k. Each valid slot carries the PC and the memory word of that lane in cycle k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| credit_i | input | CREDIT_W | Free-space credit from the reorder buffer |
| flush_i | input | 1 | Flush/redirect request |
| retired_pc_i | input | AW | PC of the last retired instruction |
| imem_addr_o | output | LANES*AW | Per-lane read addresses, lane 0 in the low bits |
| imem_en_o | output | LANES | Per-lane read enables |
| imem_data_i | input | LANES*IW | Per-lane instruction words, same-cycle read |
| grp_valid_o | output | LANES | Valid bit of each output slot |
| grp_pc_o | output | LANES*AW | PC of each slot |
| grp_instr_o | output | LANES*IW | Instruction word of each slot |
| grp_branch_o | output | LANES | Slot holds a branch |
| grp_target_o | output | LANES*AW | Predicted target of each branch slot |

## Verification
Enables and addresses come straight from state. They are checked in the same cycle the request is made, with the expected lane count taken from the credit the bench drove two cycles before. The group outputs are due one clock edge after their request. The bench therefore keeps the count and base PC of the previous cycle and compares the slots against them at the next falling edge. A PC change caused by a flush or by a normal advance is checked on lane 0 in the cycle after the inputs that caused it. All sampling happens at the falling edge, before new inputs are driven.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic {
    FM_WARMUP = 1'b0,
    FM_CREDIT = 1'b1
  } fetch_mode_e;

  function automatic int unsigned clamp_lanes(input int unsigned req, input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

endpackage

// File: rtl/fetch_credit_gate.sv
module fetch_credit_gate
  import fetch_pkg::*;
#(
  parameter int LANES    = 5,
  parameter int CREDIT_W = 4,
  parameter int WARMUP   = 2,
  parameter int LAG      = 2,
  parameter int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CREDIT_W-1:0] credit_i,
  output logic [CNT_W-1:0]    count_o
);

  localparam int WU_W = $clog2(WARMUP + 1);

  logic [LAG-1:0][CREDIT_W-1:0] lag_q;
  logic [WU_W-1:0]              warm_q;
  fetch_mode_e                  mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      lag_q <= '0;
    end else begin
      for (int s = LAG - 1; s > 0; s--) begin
        lag_q[s] <= lag_q[s-1];
      end
      lag_q[0] <= credit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q <= '0;
    end else if (mode == FM_WARMUP) begin
      warm_q <= warm_q + WU_W'(1);
    end
  end

  assign mode = (int'(warm_q) < WARMUP) ? FM_WARMUP : FM_CREDIT;

  always_comb begin
    if (mode == FM_WARMUP) begin
      count_o = CNT_W'(LANES);
    end else begin
      count_o = CNT_W'(clamp_lanes(int'(lag_q[LAG-1]), LANES));
    end
  end

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit #(
  parameter int AW       = 16,
  parameter int RESET_PC = 256,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             redirect_i,
  input  logic [AW-1:0]    retired_pc_i,
  output logic [AW-1:0]    pc_o
);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= AW'(RESET_PC);
    end else if (redirect_i) begin
      pc_q <= retired_pc_i + AW'(1);
    end else begin
      pc_q <= pc_q + AW'(count_i);
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/fetch_lane.sv
module fetch_lane #(
  parameter int           AW     = 16,
  parameter int           IW     = 32,
  parameter int           OPC_W  = 4,
  parameter logic [3:0]   BR_OPC = 4'hB,
  parameter int           LANE   = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base_pc_i,
  input  logic          active_i,
  input  logic [IW-1:0] instr_i,
  output logic [AW-1:0] addr_o,
  output logic          en_o,
  output logic          v_o,
  output logic [AW-1:0] pc_o,
  output logic [IW-1:0] instr_o,
  output logic          br_o,
  output logic [AW-1:0] tgt_o
);

  logic is_br;

  assign addr_o = base_pc_i + AW'(LANE);
  assign en_o   = active_i;
  assign is_br  = (instr_i[IW-1 -: OPC_W] == OPC_W'(BR_OPC));

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o     <= 1'b0;
      pc_o    <= '0;
      instr_o <= '0;
      br_o    <= 1'b0;
      tgt_o   <= '0;
    end else begin
      v_o     <= active_i;
      pc_o    <= active_i ? addr_o : '0;
      instr_o <= active_i ? instr_i : '0;
      br_o    <= active_i & is_br;
      tgt_o   <= (active_i && is_br) ? addr_o + AW'(1) : '0;
    end
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl #(
  parameter int         LANES    = 5,
  parameter int         AW       = 16,
  parameter int         IW       = 32,
  parameter int         CREDIT_W = 4,
  parameter int         RESET_PC = 256,
  parameter int         WARMUP   = 2,
  parameter int         LAG      = 2,
  parameter logic [3:0] BR_OPC   = 4'hB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CREDIT_W-1:0] credit_i,
  input  logic                flush_i,
  input  logic [AW-1:0]       retired_pc_i,
  output logic [LANES*AW-1:0] imem_addr_o,
  output logic [LANES-1:0]    imem_en_o,
  input  logic [LANES*IW-1:0] imem_data_i,
  output logic [LANES-1:0]    grp_valid_o,
  output logic [LANES*AW-1:0] grp_pc_o,
  output logic [LANES*IW-1:0] grp_instr_o,
  output logic [LANES-1:0]    grp_branch_o,
  output logic [LANES*AW-1:0] grp_target_o
);

  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] count;
  logic [AW-1:0]    pc;

  fetch_credit_gate #(
    .LANES(LANES), .CREDIT_W(CREDIT_W), .WARMUP(WARMUP), .LAG(LAG), .CNT_W(CNT_W)
  ) u_gate (
    .clk(clk), .rst(rst), .credit_i(credit_i), .count_o(count)
  );

  fetch_pc_unit #(
    .AW(AW), .RESET_PC(RESET_PC), .CNT_W(CNT_W)
  ) u_pc (
    .clk(clk), .rst(rst), .count_i(count), .redirect_i(flush_i),
    .retired_pc_i(retired_pc_i), .pc_o(pc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fetch_lane #(
      .AW(AW), .IW(IW), .OPC_W(4), .BR_OPC(BR_OPC), .LANE(g)
    ) u_lane (
      .clk(clk),
      .rst(rst),
      .base_pc_i(pc),
      .active_i(CNT_W'(g) < count),
      .instr_i(imem_data_i[g*IW +: IW]),
      .addr_o(imem_addr_o[g*AW +: AW]),
      .en_o(imem_en_o[g]),
      .v_o(grp_valid_o[g]),
      .pc_o(grp_pc_o[g*AW +: AW]),
      .instr_o(grp_instr_o[g*IW +: IW]),
      .br_o(grp_branch_o[g]),
      .tgt_o(grp_target_o[g*AW +: AW])
    );
  end

endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk #(
  parameter int LANES    = 5,
  parameter int AW       = 16,
  parameter int CREDIT_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [CREDIT_W-1:0] credit_i,
  input logic                flush_i,
  input logic [AW-1:0]       retired_pc_i,
  input logic [LANES*AW-1:0] imem_addr_o,
  input logic [LANES-1:0]    imem_en_o,
  input logic [LANES-1:0]    grp_valid_o,
  input logic [LANES*AW-1:0] grp_pc_o,
  input logic [LANES-1:0]    grp_branch_o,
  input logic [LANES*AW-1:0] grp_target_o
);

  logic [1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else if (cyc_q < 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grp_valid_o == '0));

  a_r3_warmup_full: assert property (@(posedge clk) disable iff (rst)
    (cyc_q < 2'd2) |-> (imem_en_o == {LANES{1'b1}}));

  a_r4_credit_lag: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == 2'd2) |-> ($countones(imem_en_o) ==
      ((int'($past(credit_i, 2)) > LANES) ? LANES : int'($past(credit_i, 2)))));

  a_r4_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((imem_en_o + LANES'(1)) & imem_en_o) == '0 || imem_en_o == {LANES{1'b1}});

  a_r6_advance: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flush_i)) |->
      (imem_addr_o[AW-1:0] == $past(imem_addr_o[AW-1:0]) + AW'($countones($past(imem_en_o)))));

  a_r7_redirect: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_i)) |->
      (imem_addr_o[AW-1:0] == $past(retired_pc_i) + AW'(1)));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (grp_valid_o == $past(imem_en_o)));

  for (genvar g = 0; g < LANES; g++) begin : g_tgt
    a_r8_target: assert property (@(posedge clk) disable iff (rst)
      (grp_valid_o[g] && grp_branch_o[g]) |->
        (grp_target_o[g*AW +: AW] == grp_pc_o[g*AW +: AW] + AW'(1)));
  end

endmodule

bind fetch_ctrl fetch_ctrl_chk #(
  .LANES(LANES), .AW(AW), .CREDIT_W(CREDIT_W)
) u_chk (
  .clk(clk), .rst(rst), .credit_i(credit_i), .flush_i(flush_i),
  .retired_pc_i(retired_pc_i), .imem_addr_o(imem_addr_o), .imem_en_o(imem_en_o),
  .grp_valid_o(grp_valid_o), .grp_pc_o(grp_pc_o), .grp_branch_o(grp_branch_o),
  .grp_target_o(grp_target_o)
);

// File: tb/fetch_ctrl_bench.sv
module fetch_ctrl_bench;

  localparam int LANES = 5;
  localparam int AW    = 16;
  localparam int IW    = 32;
  localparam int CW    = 4;
  localparam int NVEC  = 20;

  // vector: {credit[3:0], flush, retired_pc[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'd0,  1'b0, 16'h0000}, {4'd3,  1'b0, 16'h0000}, {4'd9,  1'b0, 16'h0000},
    {4'd2,  1'b0, 16'h0000}, {4'd5,  1'b0, 16'h0000}, {4'd1,  1'b1, 16'h0400},
    {4'd4,  1'b0, 16'h0000}, {4'd0,  1'b0, 16'h0000}, {4'd15, 1'b0, 16'h0000},
    {4'd5,  1'b1, 16'h1000}, {4'd2,  1'b0, 16'h0000}, {4'd0,  1'b1, 16'h2001},
    {4'd6,  1'b0, 16'h0000}, {4'd1,  1'b0, 16'h0000}, {4'd3,  1'b0, 16'h0000},
    {4'd4,  1'b1, 16'h0123}, {4'd5,  1'b0, 16'h0000}, {4'd0,  1'b0, 16'h0000},
    {4'd2,  1'b0, 16'h0000}, {4'd1,  1'b0, 16'h0000}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [CW-1:0]       credit = '0;
  logic                flush = 1'b0;
  logic [AW-1:0]       rpc = '0;
  logic [LANES*AW-1:0] imem_addr;
  logic [LANES-1:0]    imem_en;
  logic [LANES*IW-1:0] imem_data;
  logic [LANES-1:0]    grp_valid;
  logic [LANES*AW-1:0] grp_pc;
  logic [LANES*IW-1:0] grp_instr;
  logic [LANES-1:0]    grp_branch;
  logic [LANES*AW-1:0] grp_target;

  int checks = 0;
  int errors = 0;
  int k;
  int cred_hist [256];
  logic [AW-1:0] exp_pc;
  logic [AW-1:0] prev_pc;
  int prev_cnt;
  bit have_prev;
  string pc_tag;

  always #4 clk = ~clk;

  fetch_ctrl #(.LANES(LANES), .AW(AW), .IW(IW), .CREDIT_W(CW)) u_fetch_ctrl (
    .clk(clk), .rst(rst), .credit_i(credit), .flush_i(flush), .retired_pc_i(rpc),
    .imem_addr_o(imem_addr), .imem_en_o(imem_en), .imem_data_i(imem_data),
    .grp_valid_o(grp_valid), .grp_pc_o(grp_pc), .grp_instr_o(grp_instr),
    .grp_branch_o(grp_branch), .grp_target_o(grp_target)
  );

  function automatic logic [IW-1:0] memf(input logic [AW-1:0] a);
    return {((a % 3) == 0) ? 4'hB : 4'h1, 12'h000, a};
  endfunction

  function automatic logic [LANES-1:0] therm(input int n);
    return LANES'((1 << n) - 1);
  endfunction

  always_comb begin
    for (int i = 0; i < LANES; i++) imem_data[i*IW +: IW] = memf(imem_addr[i*AW +: AW]);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; credit = '0; flush = 1'b0; rpc = '0;
    repeat (3) @(negedge clk);
    chk(grp_valid == '0, "R1 valid during reset", grp_valid, 0);
    rst = 1'b0;
    k = 0; have_prev = 0; exp_pc = 16'd256; pc_tag = "R2";
  endtask

  task automatic run_cycle(input logic [CW-1:0] cr, input logic fl, input logic [AW-1:0] rp);
    int cnt;
    logic [AW-1:0] p;
    bit br;
    if (have_prev) begin
      chk(grp_valid == therm(prev_cnt), "R9 valid mask", grp_valid, therm(prev_cnt));
      for (int i = 0; i < prev_cnt; i++) begin
        p = prev_pc + AW'(i);
        br = ((p % 3) == 0);
        chk(grp_pc[i*AW +: AW] == p, "R9 slot pc", grp_pc[i*AW +: AW], p);
        chk(grp_instr[i*IW +: IW] == memf(p), "R9 slot instr", grp_instr[i*IW +: IW], memf(p));
        chk(grp_branch[i] == br, "R8 branch flag", grp_branch[i], br);
        chk(grp_target[i*AW +: AW] == (br ? p + AW'(1) : '0), "R8 target",
            grp_target[i*AW +: AW], br ? p + AW'(1) : 0);
      end
    end else begin
      chk(grp_valid == '0, "R1 empty first cycle", grp_valid, 0);
    end
    cnt = (k < 2) ? LANES : ((cred_hist[k-2] > LANES) ? LANES : cred_hist[k-2]);
    chk(imem_en == therm(cnt), (k < 2) ? "R3 warmup enables" : "R4 credit enables",
        imem_en, therm(cnt));
    chk(imem_addr[AW-1:0] == exp_pc, pc_tag, imem_addr[AW-1:0], exp_pc);
    for (int i = 1; i < cnt; i++) begin
      chk(imem_addr[i*AW +: AW] == exp_pc + AW'(i), "R5 lane addr",
          imem_addr[i*AW +: AW], exp_pc + AW'(i));
    end
    credit = cr; flush = fl; rpc = rp;
    cred_hist[k] = int'(cr);
    prev_cnt = cnt; prev_pc = exp_pc; have_prev = 1;
    exp_pc = fl ? rp + AW'(1) : exp_pc + AW'(cnt);
    pc_tag = fl ? "R7 redirect pc" : "R6 advance pc";
    k++;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int v = 0; v < NVEC; v++) run_cycle(VEC[v][20:17], VEC[v][16], VEC[v][15:0]);
    run_cycle('0, 1'b0, '0);

    // R3: zero credit during warmup still fetches full width; then R6 zero count holds pc
    do_reset();
    run_cycle(4'd0, 1'b0, '0);
    run_cycle(4'd0, 1'b0, '0);
    run_cycle(4'd0, 1'b0, '0);
    run_cycle(4'd0, 1'b0, '0);
    // R7: redirect wraps past the top of the address space
    run_cycle(4'd7, 1'b1, 16'hFFFF);
    run_cycle(4'd5, 1'b0, '0);
    run_cycle(4'd3, 1'b0, '0);
    run_cycle(4'd0, 1'b0, '0);
    run_cycle(4'd0, 1'b0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule